// File: doc/BRIEF.md
# Banked Execution Priority Resolver

This block works out the current execution priority of a processor core that has two security states, secure and non-secure. From it the block also decides whether a pending exception may preempt, and where a synchronous fault must go when it escalates: to a HardFault handler, or to lockup. It takes the banked copies of the base-priority threshold, the priority mask and the fault mask. It also takes each bank's priority-grouping field, two configuration bits and the group priority of the active exception. The last inputs describe the pending exception and the escalation request.

The configuration bits are `nsReduce` and `nsOwnsFaults`. When `nsReduce` is set, non-secure priorities are squeezed into the lower-urgency half of the range. When `nsOwnsFaults` is set, non-secure software owns fault and NMI handling. All results are registered, so they appear one clock after the inputs that produce them.

A parameter selects whether the security extension exists. Without it, the non-secure inputs and both configuration bits are ignored, and the fixed negative priorities take their original values.

Top module: `exec_prio_resolver`

## Requirements
- R1: While reset is asserted and directly after it, `execPrio` is 256, and `preempt`, `escTake` and `lockup` are 0.
- R2: Every output is the registered result of the inputs sampled at the previous rising clock edge. With no mask set, `execPrio` is `activePrio` when `activeValid` is 1, and 256 when it is 0.
- R3: A nonzero secure base threshold v lowers the running priority to v with its subpriority bits cleared. For prigroup value g, the subpriority bits are bits [g:0]. A nonzero non-secure threshold works the same way using the non-secure prigroup, but is first mapped to (v>>1)|0x80 when `nsReduce` is 1. A threshold of 0 has no effect.
- R4: A set secure priority mask gives priority 0. A set non-secure priority mask gives 0, or 0x80 when `nsReduce` is 1.
- R5: A set secure fault mask gives -1. A set non-secure fault mask gives -1 when `nsOwnsFaults` is 1; otherwise it gives 0, or 0x80 when `nsReduce` is 1.
- R6: The threshold, priority-mask and fault-mask contributions are applied in turn. Each one replaces the running value only when it is numerically lower, so `execPrio` is the lowest of them all.
- R7: A programmable pending exception (`pendKind` 0) is compared by its group priority. That is its raw priority, mapped as in R3 when it is non-secure and `nsReduce` is 1, with bits [g:0] cleared, where g is the prigroup of its own bank. `preempt` is 1 exactly when `pendValid` is 1 and this group priority is strictly lower than `execPrio`.
- R8: The fixed priorities are never masked. They are: NMI (`pendKind` 1) -2; Reset (`pendKind` 3) -4; secure HardFault (`pendKind` 2, `pendSecure` 1) -3 when `nsOwnsFaults` is 1 and -1 otherwise; non-secure HardFault -1.
- R9: A non-secure HardFault never sets `preempt` while `nsOwnsFaults` is 0.
- R10: When `escReq` is 1, `lockup` is 1 if `execPrio` is at or below the priority of the chosen HardFault (secure when `escSecure` is 1, values as in R8), and `escTake` is 1 otherwise. Both are 0 when `escReq` is 0.
- R11: With `SEC_EXT` = 0, the non-secure mask inputs, `nsReduce`, `nsOwnsFaults`, `pendSecure` and `escSecure` have no effect. All exceptions use the secure-bank prigroup, HardFault is -1 and Reset is -3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| basepriS | input | PW | Secure base-priority threshold, 0 = off |
| basepriNs | input | PW | Non-secure base-priority threshold, 0 = off |
| primaskS | input | 1 | Secure priority mask |
| primaskNs | input | 1 | Non-secure priority mask |
| faultmaskS | input | 1 | Secure fault mask |
| faultmaskNs | input | 1 | Non-secure fault mask |
| prigroupS | input | GW | Secure priority-grouping field |
| prigroupNs | input | GW | Non-secure priority-grouping field |
| nsReduce | input | 1 | Map non-secure priorities into the lower-urgency half |
| nsOwnsFaults | input | 1 | Non-secure side owns fault and NMI handling |
| activeValid | input | 1 | An exception is active |
| activePrio | input | PW+2 | Signed group priority of the active exception |
| pendValid | input | 1 | An exception is pending |
| pendKind | input | 2 | 0 programmable, 1 NMI, 2 HardFault, 3 Reset |
| pendSecure | input | 1 | Pending exception belongs to the secure bank |
| pendPrio | input | PW | Raw priority of a programmable pending exception |
| escReq | input | 1 | A synchronous fault requests escalation |
| escSecure | input | 1 | Escalation targets the secure HardFault |
| execPrio | output | PW+2 | Signed execution priority |
| preempt | output | 1 | Pending exception may preempt |
| escTake | output | 1 | Escalation is taken as HardFault |
| lockup | output | 1 | Escalation enters lockup |

## Verification
A wrong step in the mask chain shows directly on `execPrio` one clock after the inputs change. Examples are an override applied in the wrong direction, a group mask applied to a negative value, or the wrong bank's prigroup. Because `preempt`, `escTake` and `lockup` are all derived from that same priority, a bad bank choice or a bad fixed value for a HardFault shows on those flags in the same cycle. The sweeps cover every mask and configuration combination, every prigroup, and both banks, so each such fault reaches a compared output within one cycle of the vector that exposes it.

// File: rtl/prio_pkg.sv
package prio_pkg;

  typedef enum logic [1:0] {
    KIND_PROG  = 2'd0,
    KIND_NMI   = 2'd1,
    KIND_HF    = 2'd2,
    KIND_RESET = 2'd3
  } pendKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic secExt;      // security extension present
    logic nsActive;    // non-secure mask copies take part
    logic reduceNs;    // non-secure priorities are squeezed
    logic nsFaultFull; // non-secure fault mask reaches -1
    logic blockNsHf;   // non-secure HardFault may not preempt
    logic secHfHigh;   // secure HardFault sits at -3
    logic pendUseNs;   // pending exception uses non-secure bank
    logic escUseNs;    // escalation uses non-secure HardFault
  } ctlStrobes_t;

endpackage

// File: rtl/prio_ctl.sv
module prio_ctl
  import prio_pkg::*;
#(
  parameter int SEC_EXT = 1
) (
  input  logic        nsReduce,
  input  logic        nsOwnsFaults,
  input  logic        pendSecure,
  input  logic        escSecure,
  output ctlStrobes_t strb
);
  localparam logic HAS_SEC = (SEC_EXT != 0);

  always_comb begin
    strb.secExt      = HAS_SEC;
    strb.nsActive    = HAS_SEC;
    strb.reduceNs    = HAS_SEC & nsReduce;
    strb.nsFaultFull = HAS_SEC & nsOwnsFaults;
    strb.blockNsHf   = HAS_SEC & ~nsOwnsFaults;
    strb.secHfHigh   = HAS_SEC & nsOwnsFaults;
    strb.pendUseNs   = HAS_SEC & ~pendSecure;
    strb.escUseNs    = HAS_SEC & ~escSecure;
  end
endmodule

// File: rtl/prio_dp.sv
module prio_dp
  import prio_pkg::*;
#(
  parameter int PW = 8,
  parameter int GW = 3,
  localparam int EW = PW + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  ctlStrobes_t          strb,
  input  logic [PW-1:0]        basepriS,
  input  logic [PW-1:0]        basepriNs,
  input  logic                 primaskS,
  input  logic                 primaskNs,
  input  logic                 faultmaskS,
  input  logic                 faultmaskNs,
  input  logic [GW-1:0]        prigroupS,
  input  logic [GW-1:0]        prigroupNs,
  input  logic                 activeValid,
  input  logic signed [EW-1:0] activePrio,
  input  logic                 pendValid,
  input  pendKind_e            pendKind,
  input  logic [PW-1:0]        pendPrio,
  input  logic                 escReq,
  output logic signed [EW-1:0] execPrio,
  output logic                 preempt,
  output logic                 escTake,
  output logic                 lockup
);
  localparam logic signed [EW-1:0] NOPRIO  = EW'(1 << PW);
  localparam logic signed [EW-1:0] HALF    = EW'(1 << (PW - 1));
  localparam logic signed [EW-1:0] ZERO    = '0;
  localparam logic signed [EW-1:0] PRIO_M1 = EW'(-1);
  localparam logic signed [EW-1:0] PRIO_M2 = EW'(-2);
  localparam logic signed [EW-1:0] PRIO_M3 = EW'(-3);
  localparam logic signed [EW-1:0] PRIO_M4 = EW'(-4);

  function automatic logic [PW-1:0] grpMask(input logic [GW-1:0] g);
    logic [PW-1:0] m;
    m = ({PW{1'b1}} << g) << 1;
    return m;
  endfunction

  function automatic logic [PW-1:0] squeeze(input logic [PW-1:0] v);
    return {1'b1, v[PW-1:1]};
  endfunction

  function automatic logic signed [EW-1:0] toS(input logic [PW-1:0] v);
    return $signed({2'b00, v});
  endfunction

  logic signed [EW-1:0] runPrio, cand, pendGrp, secHfPrio, escHfPrio;
  logic [PW-1:0] nsBase, pendRaw;
  logic preemptN, lockupN;

  // Running minimum: threshold, then priority mask, then fault mask
  always_comb begin
    runPrio = activeValid ? activePrio : NOPRIO;
    if (basepriS != '0) begin
      cand = toS(basepriS & grpMask(prigroupS));
      if (cand < runPrio) runPrio = cand;
    end
    nsBase = strb.reduceNs ? squeeze(basepriNs) : basepriNs;
    cand = toS(nsBase & grpMask(prigroupNs));
    if (strb.nsActive && basepriNs != '0 && cand < runPrio) runPrio = cand;
    if (primaskS && ZERO < runPrio) runPrio = ZERO;
    cand = strb.reduceNs ? HALF : ZERO;
    if (strb.nsActive && primaskNs && cand < runPrio) runPrio = cand;
    if (faultmaskS && PRIO_M1 < runPrio) runPrio = PRIO_M1;
    cand = strb.nsFaultFull ? PRIO_M1 : (strb.reduceNs ? HALF : ZERO);
    if (strb.nsActive && faultmaskNs && cand < runPrio) runPrio = cand;
  end

  // Pending group priority and escalation target
  always_comb begin
    secHfPrio = strb.secHfHigh ? PRIO_M3 : PRIO_M1;
    pendRaw   = (strb.pendUseNs && strb.reduceNs) ? squeeze(pendPrio) : pendPrio;
    unique case (pendKind)
      KIND_PROG:  pendGrp = toS(pendRaw & grpMask(strb.pendUseNs ? prigroupNs : prigroupS));
      KIND_NMI:   pendGrp = PRIO_M2;
      KIND_HF:    pendGrp = strb.pendUseNs ? PRIO_M1 : secHfPrio;
      default:    pendGrp = strb.secExt ? PRIO_M4 : PRIO_M3;
    endcase
    preemptN  = pendValid && (pendGrp < runPrio) &&
                !(pendKind == KIND_HF && strb.pendUseNs && strb.blockNsHf);
    escHfPrio = strb.escUseNs ? PRIO_M1 : secHfPrio;
    lockupN   = escReq && (runPrio <= escHfPrio);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      execPrio <= NOPRIO;
      preempt  <= 1'b0;
      escTake  <= 1'b0;
      lockup   <= 1'b0;
    end else begin
      execPrio <= runPrio;
      preempt  <= preemptN;
      escTake  <= escReq && !lockupN;
      lockup   <= lockupN;
    end
  end

  // R4
  primask_s_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(primaskS) |-> execPrio <= ZERO);
  // R5
  faultmask_s_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(faultmaskS) |-> execPrio <= PRIO_M1);
  // R7
  preempt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    preempt |-> $past(pendValid));
  // R9
  ns_hf_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(pendKind == KIND_HF && strb.pendUseNs && strb.blockNsHf)
    |-> !preempt);
  // R10
  esc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lockup && escTake));
  // R10
  esc_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lockup || escTake) |-> $past(escReq));
endmodule

// File: rtl/exec_prio_resolver.sv
module exec_prio_resolver
  import prio_pkg::*;
#(
  parameter int SEC_EXT = 1,
  parameter int PW      = 8,
  parameter int GW      = 3,
  localparam int EW     = PW + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PW-1:0]        basepriS,
  input  logic [PW-1:0]        basepriNs,
  input  logic                 primaskS,
  input  logic                 primaskNs,
  input  logic                 faultmaskS,
  input  logic                 faultmaskNs,
  input  logic [GW-1:0]        prigroupS,
  input  logic [GW-1:0]        prigroupNs,
  input  logic                 nsReduce,
  input  logic                 nsOwnsFaults,
  input  logic                 activeValid,
  input  logic signed [EW-1:0] activePrio,
  input  logic                 pendValid,
  input  logic [1:0]           pendKind,
  input  logic                 pendSecure,
  input  logic [PW-1:0]        pendPrio,
  input  logic                 escReq,
  input  logic                 escSecure,
  output logic signed [EW-1:0] execPrio,
  output logic                 preempt,
  output logic                 escTake,
  output logic                 lockup
);
  ctlStrobes_t strb;

  prio_ctl #(.SEC_EXT(SEC_EXT)) u_ctl (
    .nsReduce(nsReduce), .nsOwnsFaults(nsOwnsFaults),
    .pendSecure(pendSecure), .escSecure(escSecure), .strb(strb)
  );

  prio_dp #(.PW(PW), .GW(GW)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .basepriS(basepriS), .basepriNs(basepriNs),
    .primaskS(primaskS), .primaskNs(primaskNs),
    .faultmaskS(faultmaskS), .faultmaskNs(faultmaskNs),
    .prigroupS(prigroupS), .prigroupNs(prigroupNs),
    .activeValid(activeValid), .activePrio(activePrio),
    .pendValid(pendValid), .pendKind(pendKind_e'(pendKind)),
    .pendPrio(pendPrio), .escReq(escReq),
    .execPrio(execPrio), .preempt(preempt),
    .escTake(escTake), .lockup(lockup)
  );
endmodule

// File: tb/sim_exec_prio_resolver.sv
module sim_exec_prio_resolver;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] basepriS, basepriNs, pendPrio;
  logic primaskS, primaskNs, faultmaskS, faultmaskNs;
  logic [2:0] prigroupS, prigroupNs;
  logic nsReduce, nsOwnsFaults, activeValid, pendValid, pendSecure, escReq, escSecure;
  logic signed [9:0] activePrio;
  logic [1:0] pendKind;
  logic signed [9:0] execPrio0, execPrio1;
  logic preempt0, preempt1, escTake0, escTake1, lockup0, lockup1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exec_prio_resolver #(.SEC_EXT(1)) u0 (
    .clk, .rst_n, .basepriS, .basepriNs, .primaskS, .primaskNs,
    .faultmaskS, .faultmaskNs, .prigroupS, .prigroupNs, .nsReduce, .nsOwnsFaults,
    .activeValid, .activePrio, .pendValid, .pendKind, .pendSecure, .pendPrio,
    .escReq, .escSecure, .execPrio(execPrio0), .preempt(preempt0),
    .escTake(escTake0), .lockup(lockup0));

  exec_prio_resolver #(.SEC_EXT(0)) u1 (
    .clk, .rst_n, .basepriS, .basepriNs, .primaskS, .primaskNs,
    .faultmaskS, .faultmaskNs, .prigroupS, .prigroupNs, .nsReduce, .nsOwnsFaults,
    .activeValid, .activePrio, .pendValid, .pendKind, .pendSecure, .pendPrio,
    .escReq, .escSecure, .execPrio(execPrio1), .preempt(preempt1),
    .escTake(escTake1), .lockup(lockup1));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Group priority: clear bits [g:0]
  function automatic int gm(int v, int g);
    return v - (v % (2 << g));
  endfunction

  function automatic int sq(int v);
    return v / 2 + 128;
  endfunction

  function automatic int lower(int a, int b);
    return (b < a) ? b : a;
  endfunction

  function automatic int refExec(bit se);
    int r;
    r = activeValid ? int'(activePrio) : 256;
    if (basepriS != 0) r = lower(r, gm(basepriS, prigroupS));
    if (se && basepriNs != 0) r = lower(r, gm(nsReduce ? sq(basepriNs) : basepriNs, prigroupNs));
    if (primaskS) r = lower(r, 0);
    if (se && primaskNs) r = lower(r, nsReduce ? 128 : 0);
    if (faultmaskS) r = lower(r, -1);
    if (se && faultmaskNs) r = lower(r, nsOwnsFaults ? -1 : (nsReduce ? 128 : 0));
    return r;
  endfunction

  function automatic int secHf(bit se);
    return (se && nsOwnsFaults) ? -3 : -1;
  endfunction

  function automatic int refPend(bit se);
    bit ns = se && !pendSecure;
    case (pendKind)
      2'd0: return ns ? gm(nsReduce ? sq(pendPrio) : pendPrio, prigroupNs)
                      : gm(pendPrio, prigroupS);
      2'd1: return -2;
      2'd2: return ns ? -1 : secHf(se);
      default: return se ? -4 : -3;
    endcase
  endfunction

  function automatic bit refPreempt(bit se);
    bit blocked = se && pendKind == 2'd2 && !pendSecure && !nsOwnsFaults;
    return pendValid && (refPend(se) < refExec(se)) && !blocked;
  endfunction

  function automatic bit refLock(bit se);
    int hf = (se && !escSecure) ? -1 : secHf(se);
    return escReq && (refExec(se) <= hf);
  endfunction

  task automatic step(input string execTag, input bit full);
    int e0, e1;
    bit p0, p1, l0, l1;
    e0 = refExec(1'b1); e1 = refExec(1'b0);
    p0 = refPreempt(1'b1); p1 = refPreempt(1'b0);
    l0 = refLock(1'b1); l1 = refLock(1'b0);
    @(posedge clk);
    #1;
    check({execTag, " execPrio u0"}, int'(execPrio0), e0);
    check("R11 execPrio u1", int'(execPrio1), e1);
    check("R7/R8/R9 preempt u0", int'(preempt0), int'(p0));
    check("R11 preempt u1", int'(preempt1), int'(p1));
    if (full) begin
      check("R10 lockup u0", int'(lockup0), int'(l0));
      check("R10 escTake u0", int'(escTake0), int'(escReq && !l0));
      check("R11 lockup u1", int'(lockup1), int'(l1));
      check("R11 escTake u1", int'(escTake1), int'(escReq && !l1));
    end
  endtask

  task automatic clearInputs();
    basepriS = 0; basepriNs = 0; pendPrio = 0;
    primaskS = 0; primaskNs = 0; faultmaskS = 0; faultmaskNs = 0;
    prigroupS = 0; prigroupNs = 0; nsReduce = 0; nsOwnsFaults = 0;
    activeValid = 0; activePrio = 0; pendValid = 0; pendKind = 0;
    pendSecure = 0; escReq = 0; escSecure = 0;
  endtask

  task automatic finish();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    int bsv[3] = '{0, 8'h40, 8'h81};
    int bnv[3] = '{0, 8'h20, 8'hC3};
    int apv[4] = '{0, 8'h60, -2, 8'h40};
    int ppv[4] = '{0, 8'h3F, 8'h41, 8'hFF};
    clearInputs();
    faultmaskS = 1; activeValid = 1; activePrio = -3;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values while reset is held
    check("R1 execPrio", int'(execPrio0), 256);
    check("R1 preempt", int'(preempt0), 0);
    check("R1 escTake", int'(escTake0), 0);
    check("R1 lockup", int'(lockup0), 0);
    clearInputs();
    rst_n = 1'b1;
    #1;
    check("R1 execPrio after release", int'(execPrio0), 256);
    check("R1 lockup u1 after release", int'(lockup1), 0);

    // R2: idle value, then one-cycle latency of active priority
    step("R2", 1'b1);
    activeValid = 1; activePrio = 10'sd37;
    step("R2", 1'b1);

    // Mask sweep: R3 R4 R5 R6, R11 on u1
    for (int f = 0; f < 64; f++) begin
      for (int b = 0; b < 3; b++) begin
        for (int n = 0; n < 3; n++) begin
          for (int a = 0; a < 4; a++) begin
            {primaskS, primaskNs, faultmaskS, faultmaskNs, nsReduce, nsOwnsFaults} = 6'(f);
            prigroupS = 3'(f % 8);
            prigroupNs = 3'((f / 8) % 8);
            basepriS = 8'(bsv[b]);
            basepriNs = 8'(bnv[n]);
            activeValid = (a != 0);
            activePrio = 10'(apv[a]);
            step("R3/R4/R5/R6", 1'b0);
          end
        end
      end
    end

    // Pending and escalation sweep: R7 R8 R9 R10, R11 on u1
    clearInputs();
    pendValid = 1; escReq = 1;
    for (int k = 0; k < 4; k++) begin
      for (int bank = 0; bank < 2; bank++) begin
        for (int g = 0; g < 8; g++) begin
          for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < 4; c++) begin
              for (int a = 0; a < 4; a++) begin
                pendKind = 2'(k);
                pendSecure = bank[0];
                escSecure = bank[0];
                if (bank != 0) begin prigroupS = 3'(g); prigroupNs = 3'(7 - g); end
                else begin prigroupNs = 3'(g); prigroupS = 3'(7 - g); end
                pendPrio = 8'(ppv[p]);
                {nsReduce, nsOwnsFaults} = 2'(c);
                activeValid = (a != 0);
                activePrio = (a == 1) ? 10'sd64 : (a == 2) ? -10'sd1 : -10'sd3;
                step("R6", 1'b1);
              end
            end
          end
        end
      end
    end

    // R10: no escalation request leaves both flags low
    escReq = 0; faultmaskS = 1;
    step("R10", 1'b1);
    finish();
  end
endmodule